// File: doc/BRIEF.md
# Power Domain and Module Clock/Reset Sequencer

This block controls a group of power domains. Each domain holds a fixed number of module slices, and each slice has a clock enable and an active-low reset. Software writes a target power state for each domain and a target state for each module. It then sets the domain's bit in the command register. The sequencer carries out the change in a safe order. It drives a power-switch request to each domain, and the switch answers with a power-good level. While a domain's transition is in progress, its busy bit reads 1.

A module can be in one of four states, each with its own clock and reset effect. A single command moves a domain and all of its modules together. On power-down, every module in the domain drops to the gated-and-reset state before the power request is withdrawn. On power-up, the modules wait for power-good before they take their new states. When command bits for several domains are set, the domains are served one at a time, lowest index first.

Top module: `pwr_seq`

## Requirements
- R1: After reset, domain 0 has its power request high and its modules have clock enable 1 and reset release 1. Every other domain has its request low and its modules at 0/0. The busy register reads 0.
- R2: Module state codes map to the outputs as {reset release, clock enable}. Code 0 gives 0/0 (gated and reset). Code 1 gives 0/1 (reset with clock running). Code 2 gives 1/0 (gated, out of reset). Code 3 gives 1/1 (running). On a command for a powered domain that stays on, every module of that domain takes its requested code.
- R3: A module control value of 4 to 31 is ignored by a command. That module keeps its state, while the other modules of the same command still take their codes.
- R4: On power-down, all modules of the domain are at code 0 no later than the cycle in which the power request falls. The domain status bit drops to 0 only after power-good goes low.
- R5: On power-up, the power request rises and the modules stay at code 0 for as long as power-good is low. Once power-good is high, they take their requested codes and the domain status bit reads 1.
- R6: Writing 1 to bit d of the command register (address 0) sets busy bit d (read at address 0). The bit reads 1 until that domain's transition ends. A command written to a busy domain is ignored.
- R7: When command bits for several domains are set at the same time, the domains are processed one at a time in ascending index order. A higher domain's power request does not move while a lower one is pending.
- R8: Register map, word-indexed:
  - Domain control (bit 0) is at 0x08+d and reads back the value written.
  - Domain status is at 0x10+d; bit 0 is the current power state.
  - Module control (bits 4:0) is at 0x20+m and reads back the value written.
  - Module status is at 0x40+m; bits 1:0 are the current code.
- R9: A command for a domain that is off and stays off leaves all of its modules at code 0, whatever their control values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwr_good | input | 3 | Per-domain power-good from the switch |
| pwr_req | output | 3 | Per-domain power-on request |
| mod_clk_en | output | 6 | Per-module clock enable |
| mod_rst_n | output | 6 | Per-module reset release (active-low reset) |

## Verification
A corrupted module state register appears directly on that module's clock enable and reset pins in the same cycle. It is also visible one read away through the module status register. A sequencer stuck in a wait state leaves the busy bit set, and the bench's polling limit catches this within a few hundred cycles. An ordering fault is visible at the pins when the checks sample them:
- a power request that falls while a module still has its clock or reset released, or
- a module released before power-good.

Both show in the cycle of the fault.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int NUM_PD = 3,
  parameter int MODS_PER_PD = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_we,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  input  logic [NUM_PD-1:0]                  pwr_good,
  output logic [NUM_PD-1:0]                  pwr_req,
  output logic [NUM_PD*MODS_PER_PD-1:0]      mod_clk_en,
  output logic [NUM_PD*MODS_PER_PD-1:0]      mod_rst_n
);
  localparam int NM = NUM_PD * MODS_PER_PD;
  localparam int PD_W = (NUM_PD > 1) ? $clog2(NUM_PD) : 1;
  localparam int A_CMD = 0;
  localparam int A_PDC = 8;
  localparam int A_PDS = 16;
  localparam int A_MDC = 32;
  localparam int A_MDS = 64;

  typedef enum logic [2:0] {S_IDLE, S_START, S_PWR_UP, S_PWR_DN, S_DONE} fsm_t;

  fsm_t                     fsm_q;
  logic [PD_W-1:0]          cur_q, pick;
  logic [NUM_PD-1:0]        pd_next_q, pd_on_q, pwr_req_q, pending_q;
  logic [NM-1:0][4:0]       mod_next_q;
  logic [NM-1:0][1:0]       mod_st_q;
  logic                     apply_mods, kill_mods;

  always_comb begin
    pick = '0;
    for (int d = NUM_PD - 1; d >= 0; d--)
      if (pending_q[d]) pick = PD_W'(d);
  end

  assign apply_mods = (fsm_q == S_START && pd_on_q[cur_q] && pd_next_q[cur_q]) ||
                      (fsm_q == S_PWR_UP && pwr_good[cur_q]);
  assign kill_mods  = fsm_q == S_START && pd_on_q[cur_q] && !pd_next_q[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q     <= S_IDLE;
      cur_q     <= '0;
      pending_q <= '0;
      pd_next_q <= NUM_PD'(1);
      pd_on_q   <= NUM_PD'(1);
      pwr_req_q <= NUM_PD'(1);
    end else begin
      if (bus_we) begin
        for (int d = 0; d < NUM_PD; d++) begin
          if (bus_addr == ADDR_W'(A_CMD) && bus_wdata[d] && !pending_q[d]) pending_q[d] <= 1'b1;
          if (bus_addr == ADDR_W'(A_PDC + d)) pd_next_q[d] <= bus_wdata[0];
        end
      end
      case (fsm_q)
        S_IDLE: if (|pending_q) begin
          cur_q <= pick;
          fsm_q <= S_START;
        end
        S_START: begin
          if (!pd_on_q[cur_q] && pd_next_q[cur_q]) begin
            pwr_req_q[cur_q] <= 1'b1;
            fsm_q <= S_PWR_UP;
          end else if (pd_on_q[cur_q] && !pd_next_q[cur_q]) begin
            pwr_req_q[cur_q] <= 1'b0;
            fsm_q <= S_PWR_DN;
          end else begin
            fsm_q <= S_DONE;
          end
        end
        S_PWR_UP: if (pwr_good[cur_q]) begin
          pd_on_q[cur_q] <= 1'b1;
          fsm_q <= S_DONE;
        end
        S_PWR_DN: if (!pwr_good[cur_q]) begin
          pd_on_q[cur_q] <= 1'b0;
          fsm_q <= S_DONE;
        end
        S_DONE: begin
          pending_q[cur_q] <= 1'b0;
          fsm_q <= S_IDLE;
        end
        default: fsm_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NM; m++) begin
        mod_next_q[m] <= (m < MODS_PER_PD) ? 5'd3 : 5'd0;
        mod_st_q[m]   <= (m < MODS_PER_PD) ? 2'd3 : 2'd0;
      end
    end else begin
      for (int m = 0; m < NM; m++) begin
        if (bus_we && bus_addr == ADDR_W'(A_MDC + m)) mod_next_q[m] <= bus_wdata[4:0];
        if (int'(cur_q) == m / MODS_PER_PD) begin
          if (kill_mods) mod_st_q[m] <= 2'd0;
          else if (apply_mods && mod_next_q[m] < 5'd4) mod_st_q[m] <= mod_next_q[m][1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CMD)) bus_rdata[NUM_PD-1:0] = pending_q;
    for (int d = 0; d < NUM_PD; d++) begin
      if (bus_addr == ADDR_W'(A_PDC + d)) bus_rdata[0] = pd_next_q[d];
      if (bus_addr == ADDR_W'(A_PDS + d)) bus_rdata[0] = pd_on_q[d];
    end
    for (int m = 0; m < NM; m++) begin
      if (bus_addr == ADDR_W'(A_MDC + m)) bus_rdata[4:0] = mod_next_q[m];
      if (bus_addr == ADDR_W'(A_MDS + m)) bus_rdata[1:0] = mod_st_q[m];
    end
  end

  assign pwr_req = pwr_req_q;
  generate
    for (genvar m = 0; m < NM; m++) begin : g_out
      assign mod_clk_en[m] = mod_st_q[m][0];
      assign mod_rst_n[m]  = mod_st_q[m][1];

      assert_release_after_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_clk_en[m] && mod_rst_n[m]) |-> pwr_good[m / MODS_PER_PD]);
    end
    for (genvar d = 0; d < NUM_PD; d++) begin : g_pd
      assert_off_mods_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_req[d]) |->
          (mod_clk_en[d*MODS_PER_PD +: MODS_PER_PD] == '0 &&
           mod_rst_n[d*MODS_PER_PD +: MODS_PER_PD] == '0));

      assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending_q[d]) |-> $past(fsm_q) == S_DONE);
    end
  endgenerate

  assert_req_moves_in_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_req) |-> $past(fsm_q) == S_START);

  assert_one_req_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_req ^ $past(pwr_req)) <= 1);
endmodule

// File: tb/sim_pwr_seq.sv
module sim_pwr_seq;
  localparam int PERIOD = 10;
  localparam int NPD = 3;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPD-1:0] pwr_good = '0;
  logic [NPD-1:0] pwr_req;
  logic [NM-1:0] mod_clk_en, mod_rst_n;
  logic [NPD-1:0] freeze = '0;
  logic [NPD-1:0][2:0] sh = '0;
  int vectors = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pwr_seq u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_good(pwr_good),
    .pwr_req(pwr_req), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n));

  always_ff @(posedge clk) begin
    for (int d = 0; d < NPD; d++) begin
      sh[d] <= {sh[d][1:0], pwr_req[d]};
      if (!freeze[d]) pwr_good[d] <= sh[d][2];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(8'h00, v);
      if (v[NPD-1:0] == '0) return;
    end
    check({tag, " busy timeout"}, v, 32'h0);
  endtask

  function automatic logic [1:0] pins(input int m);
    return {mod_rst_n[m], mod_clk_en[m]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v);
    check("R1 busy", v, 0);
    check("R1 req", {29'd0, pwr_req}, 32'h1);
    check("R1 clk_en", {26'd0, mod_clk_en}, 32'h3);
    check("R1 rst_n", {26'd0, mod_rst_n}, 32'h3);
    rd(8'h10, v);
    check("R1 R8 pd0 status", v, 1);
  endtask

  task automatic t_states;
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      wr(8'h20, k);
      wr(8'h21, 3 - k);
      wr(8'h00, 1);
      wait_idle("R2");
      check("R2 m0 pins", {30'd0, pins(0)}, k);
      check("R2 m1 pins", {30'd0, pins(1)}, 3 - k);
      rd(8'h41, v);
      check("R8 m1 status", v, 3 - k);
    end
  endtask

  task automatic t_invalid;
    logic [31:0] v;
    wr(8'h20, 3);
    wr(8'h21, 3);
    wr(8'h00, 1);
    wait_idle("R3 prep");
    wr(8'h20, 9);
    wr(8'h21, 1);
    wr(8'h00, 1);
    wait_idle("R3");
    check("R3 m0 kept", {30'd0, pins(0)}, 3);
    check("R3 m1 applied", {30'd0, pins(1)}, 1);
    rd(8'h20, v);
    check("R8 m0 ctl readback", v, 9);
    rd(8'h40, v);
    check("R3 m0 status", v, 3);
  endtask

  task automatic t_powerup;
    logic [31:0] v;
    freeze[1] = 1'b1;
    wr(8'h09, 1);
    wr(8'h22, 3);
    wr(8'h23, 2);
    wr(8'h00, 2);
    repeat (8) @(negedge clk);
    check("R5 req high", {31'd0, pwr_req[1]}, 1);
    check("R5 m2 held", {30'd0, pins(2)}, 0);
    check("R5 m3 held", {30'd0, pins(3)}, 0);
    rd(8'h00, v);
    check("R6 busy set", v, 2);
    wr(8'h00, 2);
    rd(8'h11, v);
    check("R5 status off", v, 0);
    freeze[1] = 1'b0;
    wait_idle("R5");
    check("R5 m2 enabled", {30'd0, pins(2)}, 3);
    check("R5 m3 disabled", {30'd0, pins(3)}, 2);
    rd(8'h11, v);
    check("R5 status on", v, 1);
    repeat (3) @(negedge clk);
    rd(8'h00, v);
    check("R6 busy go ignored", v, 0);
  endtask

  task automatic t_powerdown;
    logic [31:0] v;
    freeze[1] = 1'b1;
    wr(8'h09, 0);
    wr(8'h00, 2);
    repeat (6) @(negedge clk);
    check("R4 req low", {31'd0, pwr_req[1]}, 0);
    check("R4 m2 srd", {30'd0, pins(2)}, 0);
    check("R4 m3 srd", {30'd0, pins(3)}, 0);
    rd(8'h11, v);
    check("R4 status still on", v, 1);
    freeze[1] = 1'b0;
    wait_idle("R4");
    rd(8'h11, v);
    check("R4 status off", v, 0);
  endtask

  task automatic t_off_stays;
    wr(8'h24, 3);
    wr(8'h25, 1);
    wr(8'h0A, 0);
    wr(8'h00, 4);
    wait_idle("R9");
    check("R9 m4 srd", {30'd0, pins(4)}, 0);
    check("R9 m5 srd", {30'd0, pins(5)}, 0);
    check("R9 req low", {31'd0, pwr_req[2]}, 0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    logic seen;
    seen = 1'b0;
    wr(8'h09, 1);
    wr(8'h0A, 1);
    wr(8'h00, 6);
    for (int i = 0; i < 300 && !seen; i++) begin
      rd(8'h00, v);
      if (v[1] && pwr_req[2]) check("R7 d2 early", 1, 0);
      if (!v[1]) begin
        seen = 1'b1;
        check("R7 d2 still busy", v[2], 1);
      end
    end
    check("R7 d1 finished", seen, 1);
    wait_idle("R7");
    check("R7 both on", {29'd0, pwr_req}, 7);
    check("R7 m4 enabled", {30'd0, pins(4)}, 3);
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    repeat (6) @(negedge clk);
    t_states();
    t_invalid();
    t_powerup();
    t_powerdown();
    t_off_stays();
    t_order();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule